// File: doc/BRIEF.md
# Registered Signed Adder-Subtractor

This block adds or subtracts two small two's-complement operands. The operands and the operation select are sampled into flip-flops on a rising clock edge. A single ripple chain of full-adder cells then computes the result, and the result is captured on the following edge together with a signed overflow flag. Subtraction uses the same chain. The second operand is inverted and the select bit enters as the carry into the least significant cell.

The overflow flag reports that the true signed result does not fit in the result width. The flag comes from the carries around the top cell, not from the unsigned carry-out. Because the select bit travels with its operands, a new operation can be presented every cycle, and each result always matches the operation that was captured with it.

Top module: `regd_addsub`

## Requirements
- R1: While `rst_n` is low, `res` and `ovf` are 0, and asserting `rst_n` low clears them without waiting for a clock edge.
- R2: With `sub_en` = 0, `res` equals (`opa` + `opb`) modulo 2^W, where W = 4 by default.
- R3: With `sub_en` = 1, `res` equals (`opa` − `opb`) modulo 2^W.
- R4: Operands are read as signed two's-complement values in the range −8..7. `ovf` is 1 exactly when the true signed sum or difference lies outside −8..7.
- R5: `ovf` is not the unsigned carry-out. For example, 15 + 1 gives `res` = 0 with `ovf` = 0.
- R6: A result appears two rising edges after its operands are presented: one edge captures the inputs and one captures the result.
- R7: `sub_en` is captured with the operands. Changing it on the next cycle does not alter the result of the operation already captured.
- R8: Reset also clears the operand registers. The first result after reset is released is therefore 0 with `ovf` = 0, whatever the inputs were during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| opa | input | W | First operand (minuend in subtract mode) |
| opb | input | W | Second operand (subtrahend in subtract mode) |
| sub_en | input | 1 | 0 selects addition, 1 selects subtraction |
| res | output | W | Registered result |
| ovf | output | 1 | Registered signed overflow flag |

## Verification
The hardest case to reach is a full pipeline where the operation select flips on every cycle. In that state a mode bit that is not aligned with its operands would go unnoticed. The stimulus streams all 512 operand and mode combinations back to back with the mode bit toggling each cycle, so every combination of carry-out and signed overflow is met in both directions. Short directed sequences cover the reset corners: an asynchronous clear in the middle of the stream, and the first result after release.

// File: rtl/regd_addsub.sv
module regd_addsub #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         sub_en,
  output logic [W-1:0] res,
  output logic         ovf
);

  logic [W-1:0] a_q, b_q;
  logic         m_q;
  logic [W-1:0] b_eff, sum;
  logic [W:0]   cy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
      m_q <= 1'b0;
    end else begin
      a_q <= opa;
      b_q <= opb;
      m_q <= sub_en;
    end
  end

  assign b_eff = b_q ^ {W{m_q}};
  assign cy[0] = m_q;

  for (genvar i = 0; i < W; i++) begin : g_cell
    assign sum[i]  = a_q[i] ^ b_eff[i] ^ cy[i];
    assign cy[i+1] = (a_q[i] & b_eff[i]) | (cy[i] & (a_q[i] ^ b_eff[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res <= '0;
      ovf <= 1'b0;
    end else begin
      res <= sum;
      ovf <= cy[W] ^ cy[W-1];
    end
  end

endmodule

// File: rtl/regd_addsub_chk.sv
module regd_addsub_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic         sub_en,
  input logic [W-1:0] res,
  input logic         ovf
);

  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  function automatic logic sovf(logic [W-1:0] a, logic [W-1:0] b, logic m);
    logic signed [W+1:0] t;
    t = m ? ($signed({{2{a[W-1]}}, a}) - $signed({{2{b[W-1]}}, b}))
          : ($signed({{2{a[W-1]}}, a}) + $signed({{2{b[W-1]}}, b}));
    return (t > $signed((W+2)'((1 << (W-1)) - 1))) ||
           (t < -$signed((W+2)'(1 << (W-1))));
  endfunction

  always @(negedge clk)
    if (!rst_n) a_r1_reset_clear: assert (res == '0 && !ovf);

  a_r2_add_result: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2 && !$past(sub_en, 2)) |-> res == W'($past(opa, 2) + $past(opb, 2)));

  a_r3_sub_result: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2 && $past(sub_en, 2)) |-> res == W'($past(opa, 2) - $past(opb, 2)));

  a_r4_signed_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    age == 2'd2 |-> ovf == sovf($past(opa, 2), $past(opb, 2), $past(sub_en, 2)));

endmodule

bind regd_addsub regd_addsub_chk #(.W(W)) u_chk (.*);

// File: tb/regd_addsub_test.sv
module regd_addsub_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] opa = '0, opb = '0;
  logic       sub_en = 1'b0;
  logic [3:0] res;
  logic       ovf;
  int total = 0, bad = 0;
  bit done = 0;

  regd_addsub #(.W(4)) uut (.*);

  always #2.5 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic int sx(logic [3:0] v);
    return v[3] ? int'(v) - 16 : int'(v);
  endfunction

  task automatic expect_vec(logic [3:0] a, logic [3:0] b, logic m);
    int t;
    t = m ? sx(a) - sx(b) : sx(a) + sx(b);
    if (m) chk("R3 sub res", res, t & 15);
    else   chk("R2 add res", res, t & 15);
    chk("R4 ovf", ovf, (t > 7 || t < -8) ? 1 : 0);
    if (!m && (int'(a) + int'(b)) > 15 && t >= -8 && t <= 7)
      chk("R5 carry not ovf", ovf, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    chk("watchdog", 0, 1);
    finish_run();
  end

  initial begin
    opa = 4'd7; opb = 4'd5; sub_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 res in reset", res, 0);
    chk("R1 ovf in reset", ovf, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 first res", res, 0);
    chk("R8 first ovf", ovf, 0);
    @(negedge clk);
    chk("R6 latency res", res, 12);
    chk("R6 latency ovf", ovf, 1);

    // R7: same operands, mode flipped on the following cycle
    opa = 4'd3; opb = 4'd2; sub_en = 1'b1;
    @(negedge clk);
    sub_en = 1'b0;
    @(negedge clk);
    chk("R7 sub kept", res, 1);
    @(negedge clk);
    chk("R7 add kept", res, 5);

    // exhaustive stream, mode toggles every cycle
    for (int k = 0; k < 514; k++) begin
      if (k >= 2) begin
        logic [8:0] v;
        v = 9'(k - 2);
        expect_vec(v[4:1], v[8:5], v[0]);
      end
      if (k < 512) begin
        logic [8:0] w;
        w = 9'(k);
        opa = w[4:1]; opb = w[8:5]; sub_en = w[0];
      end
      @(negedge clk);
    end

    // R1: asynchronous clear mid-stream, away from any edge
    opa = 4'd15; opb = 4'd15; sub_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 pre-reset res", res, 14);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R1 async res", res, 0);
    chk("R1 async ovf", ovf, 0);
    @(negedge clk);
    rst_n = 1'b1;
    opa = 4'd15; opb = 4'd1; sub_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R5 15+1 res", res, 0);
    chk("R5 15+1 ovf", ovf, 0);
    finish_run();
  end
endmodule